// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar in packed BCD. A free-running tick input drives a prescaler. After `PRESCALE` ticks the block advances one second, and carries ripple through minutes, hours, date, month, year and century. A separate day-of-week counter advances at every midnight. Leap years are handled from the two year digits.

Software-style access uses a single-cycle write port that loads one field at a time. The block checks every value before it accepts it. A value that is out of range, or is not BCD, is dropped. Each accepted write restarts the sub-second phase, so the next advance comes one full second later.

A combinational read port returns any field in its packed layout, plus a status byte. Bit 0 of the status byte flags that the time has not been set since power-up.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the fields read seconds 00h, minutes 00h, hour 80h, date 01h, month 01h, year 00h, century 20h and day-of-week 0. The status byte reads 01h.
- R2: Seconds and minutes count in BCD from 00h to 59h. Seconds 59h wraps to 00h and increments minutes. Minutes 59h wraps to 00h and carries into the hour.
- R3: When hour bit 7 is 1 the hour is in 24-hour form, with BCD 00h-23h in bits 5:0. Hour 23 wraps to 00 and advances the date and the day-of-week.
- R4: When hour bit 7 is 0 the hour is in 12-hour form. Bits 4:0 hold BCD 01h-12h and bit 5 marks PM. Going from 11 to 12 toggles bit 5. Going from 12 to 01 keeps bit 5. The date advances only on PM 11 to AM 12.
- R5: The date wraps to 01h after the last day of the month. Months 04h, 06h, 09h and 11h have 30 days; all others except February have 31. Month 12h wraps to 01h and advances the year.
- R6: February has 29 days when the BCD year is divisible by four, and 28 days otherwise.
- R7: Year 99h wraps to 00h and sets the century to 20h. The century stays at 20h from then on.
- R8: Day-of-week counts 0 to 6 and wraps to 0 at midnight, whatever the date.
- R9: Writes use these addresses: 0 seconds, 1 minutes, 2 hour, 3 date, 4 month, 5 year, 6 day-of-week, 7 century. A write is ignored unless both digits are BCD and the value is in the field's range. Bit 6 of the hour must be 0. The date must be from 01h to the length of the current month. The day-of-week must be 0-6. The century must be 19h or 20h.
- R10: One second lasts `PRESCALE` cycles with the tick input high. An accepted write restarts this count; a rejected write leaves it running.
- R11: Status bit 0 (address 8) is set by reset and cleared only by an accepted field write. The status byte cannot be written.
- R12: An accepted month or year write lowers the date to the new month length when the date exceeds it.
- R13: The read port returns the field selected by the R9 address map, the status byte at address 8, and 00h at any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescaler tick; PRESCALE ticks make one second |
| wr_en_i | input | 1 | Field write strobe |
| wr_addr_i | input | 4 | Field address for writes |
| wr_data_i | input | 8 | Packed BCD value to load |
| rd_addr_i | input | 4 | Field address for reads |
| rd_data_o | output | 8 | Packed value of the addressed field |

## Verification
The bench builds the block with `PRESCALE` = 4, so one second is four tick cycles. With that setting every rollover is reachable in a few cycles once the fields are preset through the write port: midnight in both hour formats, month ends, leap Februaries and the century step. The small prescaler also lets the bench check the restart of the second phase cycle by cycle, with three ticks before a write and three after it.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef struct packed {
        logic [7:0] cent;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] hour;
        logic [7:0] minute;
        logic [7:0] second;
        logic [2:0] dow;
    } rtc_time_t;

    typedef enum logic [3:0] {
        FA_SEC   = 4'd0,
        FA_MIN   = 4'd1,
        FA_HOUR  = 4'd2,
        FA_DATE  = 4'd3,
        FA_MONTH = 4'd4,
        FA_YEAR  = 4'd5,
        FA_DOW   = 4'd6,
        FA_CENT  = 4'd7,
        FA_STAT  = 4'd8
    } rtc_addr_e;

    localparam rtc_time_t RTC_RESET = '{cent: 8'h20, year: 8'h00, month: 8'h01,
                                        date: 8'h01, hour: 8'h80, minute: 8'h00,
                                        second: 8'h00, dow: 3'd0};

    function automatic logic bcd_ok(input logic [7:0] v);
        return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // value mod 4 from digits: 10*T+U == 2*T+U (mod 4)
    function automatic logic leap_year(input logic [7:0] y);
        logic [3:0] u;
        u = y[4] ? (y[3:0] + 4'd2) : y[3:0];
        return u[1:0] == 2'b00;
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] m, input logic leap);
        case (m)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
    parameter int unsigned PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic restart_i,
    output logic sec_pulse_o
);
    localparam int unsigned CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_q;

    assign sec_pulse_o = tick_i && (cnt_q == LAST) && !restart_i;

    always_ff @(posedge clk) begin
        if (rst || restart_i) cnt_q <= '0;
        else if (tick_i)      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // R10
    phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (cnt_q == '0));

    // R10
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !restart_i) |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_load_unit.sv
module rtc_load_unit
    import rtc_cal_pkg::*;
(
    input  rtc_time_t  cur_i,
    input  logic       wr_en_i,
    input  logic [3:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    output logic       wr_ok_o,
    output rtc_time_t  nxt_o
);
    logic       ok;
    logic [7:0] d;
    logic [7:0] len_cur, len_new_m, len_new_y;

    assign d = wr_data_i;

    always_comb begin
        nxt_o     = cur_i;
        ok        = 1'b0;
        len_cur   = month_len(cur_i.month, leap_year(cur_i.year));
        len_new_m = month_len(d, leap_year(cur_i.year));
        len_new_y = month_len(cur_i.month, leap_year(d));
        case (wr_addr_i)
            FA_SEC: begin
                ok = bcd_ok(d) && (d <= 8'h59);
                nxt_o.second = d;
            end
            FA_MIN: begin
                ok = bcd_ok(d) && (d <= 8'h59);
                nxt_o.minute = d;
            end
            FA_HOUR: begin
                if (d[7])
                    ok = !d[6] && bcd_ok({2'b00, d[5:0]}) && (d[5:0] <= 6'h23);
                else
                    ok = !d[6] && bcd_ok({3'b000, d[4:0]}) && (d[4:0] != 5'h00)
                         && (d[4:0] <= 5'h12);
                nxt_o.hour = d;
            end
            FA_DATE: begin
                ok = bcd_ok(d) && (d != 8'h00) && (d <= len_cur);
                nxt_o.date = d;
            end
            FA_MONTH: begin
                ok = bcd_ok(d) && (d != 8'h00) && (d <= 8'h12);
                nxt_o.month = d;
                if (cur_i.date > len_new_m) nxt_o.date = len_new_m;
            end
            FA_YEAR: begin
                ok = bcd_ok(d);
                nxt_o.year = d;
                if (cur_i.date > len_new_y) nxt_o.date = len_new_y;
            end
            FA_DOW: begin
                ok = (d[7:3] == 5'd0) && (d[2:0] != 3'd7);
                nxt_o.dow = d[2:0];
            end
            FA_CENT: begin
                ok = (d == 8'h19) || (d == 8'h20);
                nxt_o.cent = d;
            end
            default: ok = 1'b0;
        endcase
        wr_ok_o = wr_en_i && ok;
    end

endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_cal_pkg::*;
(
    input  rtc_time_t cur_i,
    output rtc_time_t nxt_o
);
    logic       c_min, c_hour, c_day, c_mon, c_year;
    logic [7:0] len, h24, h12;

    always_comb begin
        nxt_o  = cur_i;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;
        len    = month_len(cur_i.month, leap_year(cur_i.year));
        h24    = bcd_inc({2'b00, cur_i.hour[5:0]});
        h12    = bcd_inc({3'b000, cur_i.hour[4:0]});

        if (cur_i.second == 8'h59) begin
            nxt_o.second = 8'h00;
            c_min = 1'b1;
        end else nxt_o.second = bcd_inc(cur_i.second);

        if (c_min) begin
            if (cur_i.minute == 8'h59) begin
                nxt_o.minute = 8'h00;
                c_hour = 1'b1;
            end else nxt_o.minute = bcd_inc(cur_i.minute);
        end

        if (c_hour) begin
            if (cur_i.hour[7]) begin
                if (cur_i.hour[5:0] == 6'h23) begin
                    nxt_o.hour = 8'h80;
                    c_day = 1'b1;
                end else nxt_o.hour = {2'b10, h24[5:0]};
            end else begin
                if (cur_i.hour[4:0] == 5'h12)
                    nxt_o.hour = {2'b00, cur_i.hour[5], 5'h01};
                else if (cur_i.hour[4:0] == 5'h11) begin
                    nxt_o.hour = {2'b00, ~cur_i.hour[5], 5'h12};
                    c_day = cur_i.hour[5];
                end else nxt_o.hour = {2'b00, cur_i.hour[5], h12[4:0]};
            end
        end

        if (c_day) begin
            nxt_o.dow = (cur_i.dow >= 3'd6) ? 3'd0 : cur_i.dow + 3'd1;
            if (cur_i.date >= len) begin
                nxt_o.date = 8'h01;
                c_mon = 1'b1;
            end else nxt_o.date = bcd_inc(cur_i.date);
        end

        if (c_mon) begin
            if (cur_i.month == 8'h12) begin
                nxt_o.month = 8'h01;
                c_year = 1'b1;
            end else nxt_o.month = bcd_inc(cur_i.month);
        end

        if (c_year) begin
            if (cur_i.year == 8'h99) begin
                nxt_o.year = 8'h00;
                nxt_o.cent = 8'h20;
            end else nxt_o.year = bcd_inc(cur_i.year);
        end
    end

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_cal_pkg::*;
#(
    parameter int unsigned PRESCALE = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic [3:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic [3:0] rd_addr_i,
    output logic [7:0] rd_data_o
);
    rtc_time_t cur_q, load_nxt, adv_nxt;
    logic      pfail_q, wr_ok, sec_pulse;

    rtc_prescale #(.PRESCALE(PRESCALE)) u_pre (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .restart_i  (wr_ok),
        .sec_pulse_o(sec_pulse)
    );

    rtc_load_unit u_load (
        .cur_i    (cur_q),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .wr_ok_o  (wr_ok),
        .nxt_o    (load_nxt)
    );

    rtc_advance u_adv (
        .cur_i(cur_q),
        .nxt_o(adv_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= RTC_RESET;
            pfail_q <= 1'b1;
        end else if (wr_ok) begin
            cur_q   <= load_nxt;
            pfail_q <= 1'b0;
        end else if (sec_pulse) begin
            cur_q   <= adv_nxt;
        end
    end

    always_comb begin
        case (rd_addr_i)
            FA_SEC:   rd_data_o = cur_q.second;
            FA_MIN:   rd_data_o = cur_q.minute;
            FA_HOUR:  rd_data_o = cur_q.hour;
            FA_DATE:  rd_data_o = cur_q.date;
            FA_MONTH: rd_data_o = cur_q.month;
            FA_YEAR:  rd_data_o = cur_q.year;
            FA_DOW:   rd_data_o = {5'd0, cur_q.dow};
            FA_CENT:  rd_data_o = cur_q.cent;
            FA_STAT:  rd_data_o = {7'd0, pfail_q};
            default:  rd_data_o = 8'h00;
        endcase
    end

    // R2
    sec_range_chk: assert property (@(posedge clk) disable iff (rst)
        bcd_ok(cur_q.second) && (cur_q.second <= 8'h59));

    // R8
    dow_range_chk: assert property (@(posedge clk) disable iff (rst)
        cur_q.dow <= 3'd6);

    // R7
    cent_value_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.cent == 8'h19) || (cur_q.cent == 8'h20));

    // R11
    pfail_norise_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(pfail_q));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_ok && !sec_pulse) |=> $stable(cur_q));

    // R5
    date_len_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.date != 8'h00) &&
        (cur_q.date <= month_len(cur_q.month, leap_year(cur_q.year))));

endmodule

// File: tb/sim_bcd_rtc_core.sv
module sim_bcd_rtc_core;
    localparam int unsigned PS = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [3:0] wr_addr_i = 4'd0;
    logic [7:0] wr_data_i = 8'd0;
    logic [3:0] rd_addr_i = 4'd0;
    logic [7:0] rd_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bcd_rtc_core #(.PRESCALE(PS)) u0 (
        .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    always #4 clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        rd_addr_i = a;
        #1;
        checks++;
        if (rd_data_o !== exp) begin
            errors++;
            $display("FAIL %s addr %0d: got %02h expected %02h", req, a, rd_data_o, exp);
        end
    endtask

    task automatic set_all(input logic [7:0] c, y, mo, dt, h, mi, s, input logic [7:0] dw);
        wr(7, c); wr(5, y); wr(4, mo); wr(3, dt);
        wr(2, h); wr(1, mi); wr(0, s); wr(6, dw);
    endtask

    task automatic t_reset();
        chk("R1", 0, 8'h00); chk("R1", 1, 8'h00); chk("R1", 2, 8'h80);
        chk("R1", 3, 8'h01); chk("R1", 4, 8'h01); chk("R1", 5, 8'h00);
        chk("R1", 6, 8'h00); chk("R1", 7, 8'h20); chk("R1", 8, 8'h01);
        chk("R13", 4'hF, 8'h00);
    endtask

    task automatic t_invalid();
        do_reset();
        wr(0, 8'h60); chk("R9", 0, 8'h00);
        wr(0, 8'h5A); chk("R9", 0, 8'h00);
        wr(2, 8'hA4); chk("R9", 2, 8'h80);
        wr(2, 8'hC1); chk("R9", 2, 8'h80);
        wr(2, 8'h13); chk("R9", 2, 8'h80);
        wr(2, 8'h00); chk("R9", 2, 8'h80);
        wr(4, 8'h13); chk("R9", 4, 8'h01);
        wr(4, 8'h00); chk("R9", 4, 8'h01);
        wr(3, 8'h32); chk("R9", 3, 8'h01);
        wr(3, 8'h1A); chk("R9", 3, 8'h01);
        wr(6, 8'h07); chk("R9", 6, 8'h00);
        wr(7, 8'h21); chk("R9", 7, 8'h20);
        chk("R11", 8, 8'h01);
        wr(8, 8'h00); chk("R11", 8, 8'h01);
        wr(1, 8'h05); chk("R11", 8, 8'h00); chk("R9", 1, 8'h05);
        wr(4, 8'h02); wr(5, 8'h23); wr(3, 8'h28);
        wr(3, 8'h29); chk("R9", 3, 8'h28);
    endtask

    task automatic t_seconds();
        wr(2, 8'h85); wr(1, 8'h58); wr(0, 8'h58);
        ticks(PS); chk("R2", 0, 8'h59);
        ticks(PS); chk("R2", 0, 8'h00); chk("R2", 1, 8'h59);
        wr(0, 8'h59);
        ticks(PS); chk("R2", 1, 8'h00); chk("R2", 2, 8'h86);
    endtask

    task automatic t_phase();
        wr(0, 8'h10);
        ticks(PS - 1); chk("R10", 0, 8'h10);
        wr(0, 8'h20);
        ticks(PS - 1); chk("R10", 0, 8'h20);
        ticks(1); chk("R10", 0, 8'h21);
        ticks(PS - 2);
        wr(0, 8'h77);
        ticks(2); chk("R10", 0, 8'h22);
    endtask

    task automatic t_h24();
        set_all(8'h20, 8'h24, 8'h06, 8'h15, 8'hA3, 8'h59, 8'h59, 8'h06);
        ticks(PS);
        chk("R3", 0, 8'h00); chk("R3", 1, 8'h00); chk("R3", 2, 8'h80);
        chk("R3", 3, 8'h16); chk("R8", 6, 8'h00); chk("R3", 4, 8'h06);
        wr(6, 8'h02); wr(2, 8'hA3); wr(1, 8'h59); wr(0, 8'h59);
        ticks(PS); chk("R8", 6, 8'h03); chk("R3", 3, 8'h17);
    endtask

    task automatic t_h12();
        set_all(8'h20, 8'h24, 8'h06, 8'h10, 8'h11, 8'h59, 8'h59, 8'h01);
        ticks(PS); chk("R4", 2, 8'h32); chk("R4", 3, 8'h10);
        wr(1, 8'h59); wr(0, 8'h59);
        ticks(PS); chk("R4", 2, 8'h21);
        wr(2, 8'h12); wr(1, 8'h59); wr(0, 8'h59);
        ticks(PS); chk("R4", 2, 8'h01); chk("R4", 3, 8'h10);
        wr(2, 8'h31); wr(1, 8'h59); wr(0, 8'h59);
        ticks(PS); chk("R4", 2, 8'h12); chk("R4", 3, 8'h11);
    endtask

    task automatic eod(input logic [7:0] y, mo, dt);
        set_all(8'h20, y, mo, dt, 8'hA3, 8'h59, 8'h59, 8'h00);
        ticks(PS);
    endtask

    task automatic t_months();
        eod(8'h25, 8'h01, 8'h31); chk("R5", 4, 8'h02); chk("R5", 3, 8'h01);
        eod(8'h25, 8'h04, 8'h30); chk("R5", 4, 8'h05); chk("R5", 3, 8'h01);
        eod(8'h25, 8'h05, 8'h30); chk("R5", 4, 8'h05); chk("R5", 3, 8'h31);
        eod(8'h24, 8'h12, 8'h31);
        chk("R5", 4, 8'h01); chk("R5", 3, 8'h01); chk("R5", 5, 8'h25);
    endtask

    task automatic t_leap();
        eod(8'h24, 8'h02, 8'h28); chk("R6", 3, 8'h29); chk("R6", 4, 8'h02);
        eod(8'h24, 8'h02, 8'h29); chk("R6", 3, 8'h01); chk("R6", 4, 8'h03);
        eod(8'h23, 8'h02, 8'h28); chk("R6", 3, 8'h01); chk("R6", 4, 8'h03);
        eod(8'h00, 8'h02, 8'h28); chk("R6", 3, 8'h29);
        eod(8'h10, 8'h02, 8'h28); chk("R6", 4, 8'h03);
        eod(8'h12, 8'h02, 8'h28); chk("R6", 3, 8'h29);
        eod(8'h96, 8'h02, 8'h28); chk("R6", 3, 8'h29);
    endtask

    task automatic t_century();
        set_all(8'h19, 8'h99, 8'h12, 8'h31, 8'hA3, 8'h59, 8'h59, 8'h00);
        chk("R7", 7, 8'h19);
        ticks(PS); chk("R7", 5, 8'h00); chk("R7", 7, 8'h20); chk("R7", 4, 8'h01);
        eod(8'h99, 8'h12, 8'h31); chk("R7", 7, 8'h20); chk("R7", 5, 8'h00);
    endtask

    task automatic t_clamp();
        set_all(8'h20, 8'h25, 8'h01, 8'h31, 8'h80, 8'h00, 8'h00, 8'h00);
        wr(4, 8'h04); chk("R12", 3, 8'h30);
        set_all(8'h20, 8'h24, 8'h02, 8'h29, 8'h80, 8'h00, 8'h00, 8'h00);
        wr(5, 8'h23); chk("R12", 3, 8'h28);
        wr(5, 8'h24); wr(4, 8'h01); wr(3, 8'h31);
        wr(4, 8'h02); chk("R12", 3, 8'h29);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_invalid();
        t_seconds();
        t_phase();
        t_h24();
        t_h12();
        t_months();
        t_leap();
        t_century();
        t_clamp();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule